// File: doc/BRIEF.md
# Serial Break and Abort Detector

This block watches a receiver's bit stream and its completed characters and keeps one status bit that reports a line break or a frame abort. In asynchronous operation a break is recognised when a character arrives whose data bits are all zero and whose stop bit was missing (a framing error). The break stays up while zero bits keep arriving. It ends on the first one bit, and at that moment the block asks the receive buffer to take exactly one null character.

In bit-oriented framed operation, the block counts consecutive one bits. Seven or more of them form an abort. The abort raises the status bit and sends one pulse that forces the receiver back into hunt. Any zero bit ends the abort. In character-synchronous operation the status bit is held low.

The status bit is intended to feed an external status-latch and interrupt unit. The two request outputs are single-cycle strobes for the receiver control logic and the receive buffer.

Top module: `brk_abort_det`

## Requirements
- R1: In asynchronous mode (mode_sel = 0), a char_done with char_data all zero and char_ferr = 1 raises brk_abt_stat in the cycle after the event.
- R2: In asynchronous mode, a completed character that is non-zero, or that is zero but has char_ferr = 0, does not raise brk_abt_stat.
- R3: While an asynchronous break is up, received 0 bits and further character events leave brk_abt_stat high. The first received 1 bit (rx_bit_vld = 1, rx_bit = 1) drops it in the following cycle.
- R4: When an asynchronous break ends, null_wr_req is high for exactly one cycle, which is the same cycle in which brk_abt_stat falls. It is never high outside asynchronous mode.
- R5: In framed mode (mode_sel = 2), brk_abt_stat rises in the cycle after the seventh consecutive valid 1 bit and falls in the cycle after a valid 0 bit. Cycles without rx_bit_vld do not break the run.
- R6: The run count saturates, so a run of any length beyond seven keeps brk_abt_stat high and does not produce another hunt pulse.
- R7: hunt_req is a single-cycle pulse issued together with the rise of brk_abt_stat when an abort is detected in framed mode.
- R8: In character-synchronous mode (mode_sel = 1) and in the unused code 3, brk_abt_stat is 0 and no requests are issued. Leaving a mode discards its pending break or run.
- R9: If a 1 bit and a null-with-framing-error character arrive in the same cycle while a break is up, the break ends, with one null request. If they arrive while no break is up, the break is set.
- R10: After reset, brk_abt_stat, hunt_req and null_wr_req are 0.
- R11: In framed mode, character events have no effect on brk_abt_stat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | 0 asynchronous, 1 character-synchronous, 2 bit-framed, 3 unused (held low) |
| rx_bit_vld | input | 1 | Strobe marking a received bit |
| rx_bit | input | 1 | Received bit value |
| char_done | input | 1 | Strobe marking a completed character |
| char_data | input | CHAR_W | Data bits of the completed character |
| char_ferr | input | 1 | Framing error flag of the completed character |
| brk_abt_stat | output | 1 | Break/abort status bit |
| hunt_req | output | 1 | One-cycle request to force the receiver into hunt |
| null_wr_req | output | 1 | One-cycle request to write one null character into the receive buffer |

## Verification
In asynchronous mode the end of a break and the completion of a new break character can fall in the same cycle. The bench provokes this both on purpose and through random stimulus that often pairs a 1 bit with a zero, framing-error character. It judges the result against a model in which an ongoing break gives way to the 1 bit and produces exactly one null request. In framed mode, the seventh one bit and a mode change can also coincide. For this case the model discards the run and expects no status and no hunt pulse.

// File: rtl/brk_det_pkg.sv
package brk_det_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'd0,
    MODE_CHARSYNC = 2'd1,
    MODE_FRAMED   = 2'd2,
    MODE_UNUSED   = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/brk_async_unit.sv
module brk_async_unit #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              char_done,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_ferr,
  output logic              brk_q,
  output logic              set_ev,
  output logic              end_ev,
  output logic              null_pulse
);
  function automatic logic is_break_char(input logic [CHAR_W-1:0] d, input logic fe);
    return (d == '0) && fe;
  endfunction

  function automatic logic is_mark(input logic v, input logic b);
    return v && b;
  endfunction

  // A 1 bit ends an ongoing break; a break character starts one only when idle.
  assign end_ev = enable && brk_q && is_mark(rx_bit_vld, rx_bit);
  assign set_ev = enable && !brk_q && char_done && is_break_char(char_data, char_ferr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q      <= 1'b0;
      null_pulse <= 1'b0;
    end else begin
      null_pulse <= end_ev;
      if (!enable)     brk_q <= 1'b0;
      else if (end_ev) brk_q <= 1'b0;
      else if (set_ev) brk_q <= 1'b1;
    end
  end
endmodule

// File: rtl/brk_ones_run.sv
module brk_ones_run #(
  parameter int ABORT_RUN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rx_bit_vld,
  input  logic rx_bit,
  output logic abort_q,
  output logic abort_ev,
  output logic hunt_pulse
);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ABORT_RUN);

  logic [RUN_W-1:0] run_q;

  function automatic logic [RUN_W-1:0] run_next(input logic [RUN_W-1:0] c, input logic b);
    if (!b)           return '0;
    if (c == RUN_MAX) return c;
    return c + 1'b1;
  endfunction

  assign abort_q  = (run_q == RUN_MAX);
  assign abort_ev = enable && rx_bit_vld && rx_bit && (run_q == RUN_MAX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      hunt_pulse <= 1'b0;
    end else begin
      hunt_pulse <= abort_ev;
      if (!enable)         run_q <= '0;
      else if (rx_bit_vld) run_q <= run_next(run_q, rx_bit);
    end
  end
endmodule

// File: rtl/brk_stat_sel.sv
module brk_stat_sel
  import brk_det_pkg::*;
(
  input  rx_mode_e mode,
  input  logic     brk_q,
  input  logic     abort_q,
  output logic     stat
);
  always_comb begin
    unique case (mode)
      MODE_ASYNC:  stat = brk_q;
      MODE_FRAMED: stat = abort_q;
      default:     stat = 1'b0;
    endcase
  end
endmodule

// File: rtl/brk_abort_det.sv
module brk_abort_det
  import brk_det_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int ABORT_RUN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              char_done,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_ferr,
  output logic              brk_abt_stat,
  output logic              hunt_req,
  output logic              null_wr_req
);
  rx_mode_e mode;
  logic     async_en, framed_en;
  logic     brk_q, brk_set_ev, brk_end_ev;
  logic     abort_q, abort_ev;

  assign mode      = rx_mode_e'(mode_sel);
  assign async_en  = (mode == MODE_ASYNC);
  assign framed_en = (mode == MODE_FRAMED);

  brk_async_unit #(.CHAR_W(CHAR_W)) u_async (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (async_en),
    .rx_bit_vld (rx_bit_vld),
    .rx_bit     (rx_bit),
    .char_done  (char_done),
    .char_data  (char_data),
    .char_ferr  (char_ferr),
    .brk_q      (brk_q),
    .set_ev     (brk_set_ev),
    .end_ev     (brk_end_ev),
    .null_pulse (null_wr_req)
  );

  brk_ones_run #(.ABORT_RUN(ABORT_RUN)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (framed_en),
    .rx_bit_vld (rx_bit_vld),
    .rx_bit     (rx_bit),
    .abort_q    (abort_q),
    .abort_ev   (abort_ev),
    .hunt_pulse (hunt_req)
  );

  brk_stat_sel u_sel (
    .mode    (mode),
    .brk_q   (brk_q),
    .abort_q (abort_q),
    .stat    (brk_abt_stat)
  );
endmodule

// File: rtl/brk_abort_det_chk.sv
module brk_abort_det_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              rx_bit_vld,
  input logic              rx_bit,
  input logic              char_done,
  input logic [CHAR_W-1:0] char_data,
  input logic              char_ferr,
  input logic              brk_abt_stat,
  input logic              hunt_req,
  input logic              null_wr_req,
  input logic              brk_set_ev,
  input logic              brk_end_ev,
  input logic              abort_ev
);
  assert_break_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0 && !brk_abt_stat && char_done && char_data == '0 && char_ferr)
      |=> (brk_abt_stat || mode_sel != 2'd0));

  assert_one_ends_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0 && brk_abt_stat && rx_bit_vld && rx_bit) |=> (null_wr_req && !brk_abt_stat));

  assert_null_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    null_wr_req |=> !null_wr_req);

  assert_null_from_async_R4: assert property (@(posedge clk) disable iff (!rst_n)
    null_wr_req |-> $past(mode_sel == 2'd0 && brk_end_ev));

  assert_hunt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_req |=> !hunt_req);

  assert_hunt_with_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_req && mode_sel == 2'd2) |-> brk_abt_stat);

  assert_hunt_from_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_req |-> $past(abort_ev));

  assert_sync_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[0] == 1'b1 && $past(mode_sel[0]) == 1'b1) |-> (!brk_abt_stat && !hunt_req && !null_wr_req));

  assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_set_ev && brk_end_ev));
endmodule

bind brk_abort_det brk_abort_det_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_sel     (mode_sel),
  .rx_bit_vld   (rx_bit_vld),
  .rx_bit       (rx_bit),
  .char_done    (char_done),
  .char_data    (char_data),
  .char_ferr    (char_ferr),
  .brk_abt_stat (brk_abt_stat),
  .hunt_req     (hunt_req),
  .null_wr_req  (null_wr_req),
  .brk_set_ev   (brk_set_ev),
  .brk_end_ev   (brk_end_ev),
  .abort_ev     (abort_ev)
);

// File: tb/brk_abort_det_tb_top.sv
module brk_abort_det_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'd0;
  logic          rx_bit_vld = 1'b0, rx_bit = 1'b0;
  logic          char_done = 1'b0, char_ferr = 1'b0;
  logic [CW-1:0] char_data = '0;
  logic          brk_abt_stat, hunt_req, null_wr_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_brk;
  int m_ones;
  bit e_null, e_hunt;

  always #10 clk = ~clk;

  brk_abort_det #(.CHAR_W(CW), .ABORT_RUN(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .char_done(char_done), .char_data(char_data), .char_ferr(char_ferr),
    .brk_abt_stat(brk_abt_stat), .hunt_req(hunt_req), .null_wr_req(null_wr_req)
  );

  function automatic bit exp_stat(input logic [1:0] m);
    if (m == 2'd0) return m_brk;
    if (m == 2'd2) return m_ones >= 7;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare after the edge.
  task automatic step(input string tag, input logic [1:0] m, input bit v, input bit b,
                      input bit cd, input logic [CW-1:0] d, input bit fe);
    @(negedge clk);
    mode_sel = m; rx_bit_vld = v; rx_bit = b;
    char_done = cd; char_data = d; char_ferr = fe;
    e_null = 1'b0; e_hunt = 1'b0;
    if (m == 2'd0) begin
      m_ones = 0;
      if (m_brk && v && b) begin m_brk = 1'b0; e_null = 1'b1; end
      else if (!m_brk && cd && d == 0 && fe) m_brk = 1'b1;
    end else if (m == 2'd2) begin
      m_brk = 1'b0;
      if (v) begin
        if (b) begin m_ones++; if (m_ones == 7) e_hunt = 1'b1; end
        else m_ones = 0;
      end
    end else begin
      m_brk = 1'b0; m_ones = 0;
    end
    @(posedge clk);
    #5;
    check(tag, "stat", brk_abt_stat, exp_stat(m));
    check(tag, "null_wr_req", null_wr_req, e_null);
    check(tag, "hunt_req", hunt_req, e_hunt);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b7a_55e3));
    m_brk = 1'b0; m_ones = 0;
    repeat (3) @(posedge clk);
    #5;
    check("R10", "stat", brk_abt_stat, 1'b0);
    check("R10", "hunt_req", hunt_req, 1'b0);
    check("R10", "null_wr_req", null_wr_req, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2: near-misses do not set a break
    step("R2", 2'd0, 0, 0, 1, 8'h00, 0);
    step("R2", 2'd0, 0, 0, 1, 8'h10, 1);
    // R1: break character sets status
    step("R1", 2'd0, 0, 0, 1, 8'h00, 1);
    // R3: zeros and more characters keep it
    for (int i = 0; i < 4; i++) step("R3", 2'd0, 1, 0, (i == 2), 8'h00, 1);
    // R3/R4: first 1 ends it with one null request
    step("R4", 2'd0, 1, 1, 0, 8'h00, 0);
    step("R4", 2'd0, 1, 1, 0, 8'h00, 0);
    // R9: coincident break character and 1 bit
    step("R9", 2'd0, 1, 1, 1, 8'h00, 1);   // idle: set wins
    step("R9", 2'd0, 1, 1, 1, 8'h00, 1);   // up: 1 ends it
    step("R9", 2'd0, 0, 0, 0, 8'h00, 0);
    // R8: break discarded on leaving async, sync stays quiet
    step("R8", 2'd0, 0, 0, 1, 8'h00, 1);
    step("R8", 2'd1, 1, 1, 1, 8'h00, 1);
    for (int i = 0; i < 9; i++) step("R8", 2'd1, 1, 1, 1, 8'h00, 1);
    step("R8", 2'd3, 1, 1, 1, 8'h00, 1);
    // R5/R7: seven ones with gaps, then abort
    for (int i = 0; i < 6; i++) begin
      step("R5", 2'd2, 1, 1, 0, 8'h00, 0);
      step("R5", 2'd2, 0, 0, 0, 8'h00, 0);
    end
    step("R7", 2'd2, 1, 1, 0, 8'h00, 0);
    // R6: long run saturates, no more hunt
    for (int i = 0; i < 20; i++) step("R6", 2'd2, 1, 1, 0, 8'h00, 0);
    // R11: character events ignored in framed mode
    step("R11", 2'd2, 0, 0, 1, 8'h00, 1);
    step("R5", 2'd2, 1, 0, 0, 8'h00, 0);
    step("R11", 2'd2, 0, 0, 1, 8'h00, 1);
    // R5: six ones then a zero gives no abort
    for (int i = 0; i < 6; i++) step("R5", 2'd2, 1, 1, 0, 8'h00, 0);
    step("R5", 2'd2, 1, 0, 0, 8'h00, 0);
    // mode change on the seventh one discards the run
    for (int i = 0; i < 6; i++) step("R8", 2'd2, 1, 1, 0, 8'h00, 0);
    step("R8", 2'd1, 1, 1, 0, 8'h00, 0);
    step("R8", 2'd2, 1, 1, 0, 8'h00, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] m;
      bit v, b, cd, fe;
      logic [CW-1:0] d;
      m  = (i % 500 < 240) ? 2'd0 : ((i % 500 < 480) ? 2'd2 : 2'($urandom_range(0, 3)));
      v  = ($urandom_range(0, 9) < 7);
      b  = (m == 2'd2) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 3);
      cd = ($urandom_range(0, 3) == 0);
      d  = ($urandom_range(0, 1) == 0) ? '0 : CW'($urandom);
      fe = ($urandom_range(0, 1) == 0);
      step("RND", m, v, b, cd, d, fe);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule